// File: doc/BRIEF.md
# Knockout Output Port Concentrator

This block is the receiving end of one output port in a fully connected, output-queued cell switch. Each of the N input lines is seen by the port on every clock cycle. One cycle is one cell slot. A per-line address comparator keeps only the cells whose destination matches the port's own address. A concentrator takes no more than L of those cells per slot, with L well below N. Extra contenders are thrown away on purpose rather than stored, and their number is added to a loss counter.

The accepted cells go into a first-in first-out queue in one slot. The queue can take up to L writes in a cycle and gives one cell per cycle to the downstream link.

The input lines are a broadcast and have no back-pressure. A cell that is valid in a cycle is offered exactly once. The output side is a valid/ready stream:
- `out_valid` is high whenever the queue holds a cell.
- `out_data` shows the oldest cell and holds still until `out_ready` is sampled high on a rising edge. That edge removes the cell.
- A stalled downstream link is absorbed by the queue. When the queue cannot take every accepted cell, the cells that do not fit are lost and a sticky flag records it.

`DEPTH` must be a power of two, and `L_ACC` must not exceed `DEPTH`.

Top module: `kout_port_concentrator`

## Requirements
- R1: A line's cell takes part in a slot only when its `in_valid` bit is 1 and its address field equals `port_addr`. Line i uses bits [i*ADDR_W +: ADDR_W] of `in_addr` and bits [i*DATA_W +: DATA_W] of `in_data`. Any other cell changes neither the output stream nor `drop_count`.
- R2: At most L_ACC matching cells are accepted per slot. The winners are the matching lines with the lowest line numbers.
- R3: The cells accepted in a slot enter the queue in ascending line order, and the output presents cells in the order they entered the queue.
- R4: In each slot, the number of matching cells beyond L_ACC is added to `drop_count`. The counter saturates at all ones and is otherwise never changed except by reset.
- R5: Free space is DEPTH minus the occupancy at the start of the slot; a read in the same cycle does not add space. Accepted cells beyond the free space are discarded, and these are the highest-numbered lines of that slot. `overflow` goes to 1 in the cycle after such a loss and stays 1 until reset. These losses do not change `drop_count`.
- R6: `out_valid` is 1 exactly when the queue is not empty. While `out_valid` is 1 and `out_ready` is 0, `out_data` stays unchanged. At most one cell leaves per cycle.
- R7: A cell accepted into an empty queue in the slot ending at a rising edge is presented on `out_valid`/`out_data` right after that edge.
- R8: After reset, `out_valid`, `drop_count` and `overflow` are all 0.
- R9: Without queue overflow, the cells delivered plus the increase of `drop_count` equal the number of matching cells offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cell slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| port_addr | input | ADDR_W | Address of this output port |
| in_valid | input | N_IN | Cell present on each input line |
| in_addr | input | N_IN*ADDR_W | Destination address per line, line i at [i*ADDR_W +: ADDR_W] |
| in_data | input | N_IN*DATA_W | Cell payload per line, line i at [i*DATA_W +: DATA_W] |
| out_valid | output | 1 | Output cell available |
| out_ready | input | 1 | Downstream accepts the presented cell |
| out_data | output | DATA_W | Oldest queued cell |
| drop_count | output | DROP_W | Saturating count of concentrator losses |
| overflow | output | 1 | Sticky: a queue-full loss has occurred |

## Verification
Address filtering is tried with a pattern that mixes matching cells, cells for other ports, and a matching address whose valid bit is low. This separates the valid qualification from the comparison.

The concentrator is driven in three ways:
- All lines contend at once.
- The matches are scattered so that the winners are not simply lines 0 to L-1.
- Pseudo-random slots are checked for conservation.

A stalled output with fills that reach exactly the queue size and then run one past it distinguishes partial-fit ordering from an all-or-nothing write. A long stretch of full contention shows that the loss counter saturates.

// File: rtl/kc_pkg.sv
package kc_pkg;

  // Width needed to hold the values 0..n inclusive.
  function automatic int kc_cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/kc_addr_filter.sv
module kc_addr_filter #(
  parameter int ADDR_W = 3
) (
  input  logic              cell_vld,
  input  logic [ADDR_W-1:0] cell_dst,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              hit
);
  assign hit = cell_vld && (cell_dst == own_addr);
endmodule

// File: rtl/kc_concentrator.sv
module kc_concentrator
  import kc_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int L_ACC  = 4,
  parameter int DATA_W = 16,
  localparam int HIT_W = kc_cnt_bits(N_IN),
  localparam int ACC_W = kc_cnt_bits(L_ACC)
) (
  input  logic [N_IN-1:0]         hit,
  input  logic [N_IN*DATA_W-1:0]  line_data,
  output logic [L_ACC*DATA_W-1:0] win_data,
  output logic [ACC_W-1:0]        win_cnt,
  output logic [HIT_W-1:0]        hit_cnt,
  output logic [HIT_W-1:0]        lost_cnt
);
  int rank;

  // Lower line numbers take the lower output lanes; lanes fill in order.
  always_comb begin
    rank     = 0;
    win_data = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (hit[i]) begin
        if (rank < L_ACC) begin
          win_data[rank*DATA_W +: DATA_W] = line_data[i*DATA_W +: DATA_W];
        end
        rank = rank + 1;
      end
    end
    hit_cnt = HIT_W'(rank);
    if (rank > L_ACC) begin
      win_cnt  = ACC_W'(L_ACC);
      lost_cnt = HIT_W'(rank - L_ACC);
    end else begin
      win_cnt  = ACC_W'(rank);
      lost_cnt = '0;
    end
  end
endmodule

// File: rtl/kc_burst_fifo.sv
module kc_burst_fifo
  import kc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int L_ACC  = 4,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = kc_cnt_bits(DEPTH),
  localparam int ACC_W = kc_cnt_bits(L_ACC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ACC_W-1:0]        wr_cnt,
  input  logic [L_ACC*DATA_W-1:0] wr_data,
  input  logic                    rd_ready,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  output logic [LVL_W-1:0]        level,
  output logic                    wr_short
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  free_sp, n_wr, want, level_nxt;
  logic              pop;

  always_comb begin
    free_sp   = LVL_W'(DEPTH) - level;
    want      = LVL_W'(wr_cnt);
    wr_short  = want > free_sp;
    n_wr      = wr_short ? free_sp : want;
    pop       = rd_valid && rd_ready;
    level_nxt = level + n_wr - LVL_W'(pop);
  end

  assign rd_valid = (level != '0);
  assign rd_data  = mem[rd_ptr];

  // Lanes below n_wr go to consecutive slots; writes only hit free slots.
  always_ff @(posedge clk) begin
    for (int j = 0; j < L_ACC; j++) begin
      if (j < int'(n_wr)) begin
        mem[wr_ptr + PTR_W'(j)] <= wr_data[j*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(n_wr);
      if (pop) rd_ptr <= rd_ptr + PTR_W'(1);
      level  <= level_nxt;
    end
  end
endmodule

// File: rtl/kout_port_concentrator.sv
module kout_port_concentrator
  import kc_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int L_ACC  = 4,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int DROP_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      port_addr,
  input  logic [N_IN-1:0]        in_valid,
  input  logic [N_IN*ADDR_W-1:0] in_addr,
  input  logic [N_IN*DATA_W-1:0] in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [DATA_W-1:0]      out_data,
  output logic [DROP_W-1:0]      drop_count,
  output logic                   overflow
);
  localparam int HIT_W = kc_cnt_bits(N_IN);
  localparam int ACC_W = kc_cnt_bits(L_ACC);
  localparam int LVL_W = kc_cnt_bits(DEPTH);
  localparam int SUM_W = (HIT_W > DROP_W) ? HIT_W + 1 : DROP_W + 1;

  logic [N_IN-1:0]         hit;
  logic [L_ACC*DATA_W-1:0] win_data;
  logic [ACC_W-1:0]        win_cnt;
  logic [HIT_W-1:0]        hit_cnt, lost_cnt;
  logic [LVL_W-1:0]        fifo_level;
  logic                    wr_short;
  logic [SUM_W-1:0]        drop_sum;

  for (genvar g = 0; g < N_IN; g++) begin : g_filt
    kc_addr_filter #(.ADDR_W(ADDR_W)) u_filt (
      .cell_vld (in_valid[g]),
      .cell_dst (in_addr[g*ADDR_W +: ADDR_W]),
      .own_addr (port_addr),
      .hit      (hit[g])
    );
  end

  kc_concentrator #(.N_IN(N_IN), .L_ACC(L_ACC), .DATA_W(DATA_W)) u_conc (
    .hit       (hit),
    .line_data (in_data),
    .win_data  (win_data),
    .win_cnt   (win_cnt),
    .hit_cnt   (hit_cnt),
    .lost_cnt  (lost_cnt)
  );

  kc_burst_fifo #(.DEPTH(DEPTH), .L_ACC(L_ACC), .DATA_W(DATA_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cnt   (win_cnt),
    .wr_data  (win_data),
    .rd_ready (out_ready),
    .rd_valid (out_valid),
    .rd_data  (out_data),
    .level    (fifo_level),
    .wr_short (wr_short)
  );

  assign drop_sum = SUM_W'(drop_count) + SUM_W'(lost_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_count <= '0;
      overflow   <= 1'b0;
    end else begin
      if (drop_sum > SUM_W'({DROP_W{1'b1}})) drop_count <= '1;
      else                                   drop_count <= DROP_W'(drop_sum);
      if (wr_short) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/kc_port_checker.sv
module kc_port_checker #(
  parameter int L_ACC  = 4,
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int DROP_W = 8,
  parameter int HIT_W  = 4,
  parameter int LVL_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [DROP_W-1:0] drop_count,
  input logic              overflow,
  input logic [HIT_W-1:0]  hit_cnt,
  input logic [LVL_W-1:0]  fifo_level
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == '0) |-> !out_valid);

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(hit_cnt) <= L_ACC) |=> $stable(drop_count));

  p_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_count >= $past(drop_count)));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_level) <= DEPTH);

  p_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(fifo_level) <= int'($past(fifo_level)) + L_ACC));
endmodule

bind kout_port_concentrator kc_port_checker #(
  .L_ACC(L_ACC), .DEPTH(DEPTH), .DATA_W(DATA_W), .DROP_W(DROP_W),
  .HIT_W(HIT_W), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .drop_count(drop_count), .overflow(overflow),
  .hit_cnt(hit_cnt), .fifo_level(fifo_level)
);

// File: tb/kout_port_concentrator_test.sv
module kout_port_concentrator_test;
  localparam int N      = 8;
  localparam int L      = 4;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int DROP_W = 8;
  localparam logic [ADDR_W-1:0] ME = 3'd5;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic [ADDR_W-1:0]      port_addr = ME;
  logic [N-1:0]           in_valid;
  logic [N*ADDR_W-1:0]    in_addr;
  logic [N*DATA_W-1:0]    in_data;
  logic                   out_valid, out_ready, overflow;
  logic [DATA_W-1:0]      out_data;
  logic [DROP_W-1:0]      drop_count;

  int checks = 0, fails = 0, delivered = 0, exp_drop = 0;
  bit exp_ovf = 0;
  logic [DATA_W-1:0] exp_q [$];

  always #5 clk = ~clk;

  kout_port_concentrator #(.N_IN(N), .L_ACC(L), .DEPTH(DEPTH), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .DROP_W(DROP_W)) uut (
    .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .in_valid(in_valid),
    .in_addr(in_addr), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .drop_count(drop_count),
    .overflow(overflow));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Offer one slot at a negedge; returns at the next negedge.
  task automatic offer(input logic [N-1:0] vld, input logic [N-1:0] mine,
                       input logic [7:0] tag);
    int acc = 0, lost = 0;
    for (int i = 0; i < N; i++) begin
      in_valid[i] = vld[i];
      in_addr[i*ADDR_W +: ADDR_W] = mine[i] ? ME : (ME ^ ADDR_W'(1 + (i % 7)));
      in_data[i*DATA_W +: DATA_W] = {tag, 8'(i)};
      if (vld[i] && mine[i]) begin
        if (acc < L) begin
          if (exp_q.size() < DEPTH) exp_q.push_back({tag, 8'(i)});
          else exp_ovf = 1;
          acc++;
        end else lost++;
      end
    end
    exp_drop = (exp_drop + lost > 255) ? 255 : exp_drop + lost;
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic drain(input string req);
    out_ready = 1'b1;
    while (out_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, req, "unexpected cell", int'(out_data), -1);
      end else begin
        logic [DATA_W-1:0] e = exp_q.pop_front();
        chk(out_data == e, req, "cell order/content", int'(out_data), int'(e));
      end
      delivered++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(exp_q.size() == 0, req, "cells missing", 0, exp_q.size());
    exp_q.delete();
  endtask

  task automatic t_reset;
    chk(out_valid == 0, "R8", "out_valid", out_valid, 0);
    chk(drop_count == 0, "R8", "drop_count", drop_count, 0);
    chk(overflow == 0, "R8", "overflow", overflow, 0);
  endtask

  task automatic t_filter;  // R1: lines 2,5 match; 6 matches but not valid
    offer(8'b1011_1111, 8'b0110_0100, 8'h11);
    chk(drop_count == 0, "R1", "drop unaffected", drop_count, 0);
    drain("R1");
  endtask

  task automatic t_all_contend;  // R2 R3 R4
    offer(8'hFF, 8'hFF, 8'h22);
    chk(int'(drop_count) == exp_drop, "R4", "drop after 8 contenders", drop_count, exp_drop);
    drain("R2");
  endtask

  task automatic t_scattered;  // R2: matches 1,2,4,5,6,7 -> 1,2,4,5 win
    offer(8'hFF, 8'b1111_0110, 8'h33);
    chk(int'(drop_count) == exp_drop, "R4", "drop after 6 contenders", drop_count, exp_drop);
    drain("R2");
  endtask

  task automatic t_stall;  // R6 R7
    logic [DATA_W-1:0] first;
    offer(8'hFF, 8'b1001_0001, 8'h44);
    chk(out_valid == 1, "R7", "valid right after slot", out_valid, 1);
    chk(out_data == 16'h4400, "R7", "first cell", int'(out_data), 16'h4400);
    first = out_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid && out_data == first, "R6", "hold under stall", int'(out_data), int'(first));
    end
    drain("R6");
    chk(out_valid == 0, "R6", "empty after drain", out_valid, 0);
  endtask

  task automatic t_overflow;  // R5
    for (int s = 0; s < 3; s++) offer(8'hFF, 8'h0F << (s % 2), 8'(8'h50 + s));
    offer(8'hFF, 8'b0111_0000, 8'h60);
    chk(overflow == 0, "R5", "no overflow at 15", overflow, 0);
    offer(8'hFF, 8'b1010_1010, 8'h61);  // only line 1 fits
    chk(overflow == 1, "R5", "overflow set", overflow, 1);
    chk(int'(drop_count) == exp_drop, "R5", "drop unchanged by overflow", drop_count, exp_drop);
    drain("R5");
    chk(overflow == 1, "R5", "overflow sticky", overflow, 1);
  endtask

  task automatic t_conserve;  // R9
    logic [15:0] lf = 16'hACE1;
    int offered = 0, d0 = int'(drop_count), out0 = delivered;
    for (int s = 0; s < 20; s++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      for (int i = 0; i < N; i++) if (lf[i] && lf[8+i]) offered++;
      offer(lf[7:0], lf[15:8], 8'(8'h80 + s));
      drain("R9");
    end
    chk((delivered - out0) + (int'(drop_count) - d0) == offered, "R9",
        "delivered+dropped vs offered", (delivered - out0) + (int'(drop_count) - d0), offered);
  endtask

  task automatic t_saturate;  // R4
    while (exp_drop < 255) begin
      offer(8'hFF, 8'hFF, 8'hC0);
      drain("R4");
    end
    offer(8'hFF, 8'hFF, 8'hC1);
    drain("R4");
    chk(drop_count == 8'hFF, "R4", "saturated drop", drop_count, 255);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; out_ready = 1'b0;
    in_valid = '0; in_addr = '0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_filter();
    t_all_contend();
    t_scattered();
    t_stall();
    t_overflow();
    t_conserve();
    t_saturate();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule